// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire Management Bus

This block is the management-bus target of a clock generator. It sits on a two-wire SMBus and holds a small bank of 8-bit registers. The registers drive the enables, stop policies and spread settings of the clock logic. The bus lines are sampled with the system clock. Open-drain behaviour is modelled by a single output that pulls SDA low whenever it is set.

Each transfer uses block framing:
- A write carries the device address, a command byte, a byte-count byte and then data bytes. The command value is ignored.
- The data bytes fill the registers in sequence, starting at register 0.
- A read returns the register count first. It then returns register 0, register 1 and so on until the master answers with a NACK.

Some register fields are not plain storage:
- Register 0 carries two read-only strap bits and a stop-status bit that combines the stored value with an external pin.
- Register 6 is a fixed signature. Writes to it are acknowledged and then discarded.
- Addresses past the last register are acknowledged on writes and read back as zero.

Top module: `clkctl_smb_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) and 0xD3 (read). For any other address it leaves SDA released, and it ignores all further bytes until the next START.
- R2: After the address, the command byte and the byte-count byte are both acknowledged. Their values have no effect on which registers are written or on the values stored.
- R3: Write data bytes land in register 0, 1, 2 and so on in arrival order, and each one is acknowledged. Register k is visible on `ctrl_o[8k+7:8k]`.
- R4: After reset the stored values are: reg0 0x09, reg1 0x87, reg2 0xF7, reg3 0xDF, reg4 0x3F, reg5 0x40, reg6 0x13, and 0x00 for reg7, reg8 and reg9.
- R5: A read of register 0 returns `strap_i[1]` at bit 2 and `strap_i[0]` at bit 1. Written values of those two bits are discarded, and they show as 0 on `ctrl_o`.
- R6: A read of register 0 returns bit 3 as the AND of its stored bit and `pci_stop_ni`. The stored bit on `ctrl_o` is not altered by the pin.
- R7: Register 6 always reads 0x13 and shows 0x13 on `ctrl_o`. A write to it is acknowledged and changes nothing.
- R8: The first byte of a read is the register count, 10 (0x0A). Later bytes are register 0 onward, and the read continues while the master acknowledges. After a master NACK the slave releases SDA.
- R9: Data bytes addressed past register 9 are acknowledged on writes and have no effect. On reads they return 0x00.
- R10: A START, including a repeated START, restarts the framing at the address byte. A STOP ends the transfer. The slave changes SDA only while SCL is low.
- R11: Register contents persist across transfers, including a transfer aborted by a STOP in mid-byte. Only `rst_ni` restores the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_i | input | 2 | Live strap levels, bit 1 and bit 0 |
| pci_stop_ni | input | 1 | External active-low stop pin, combined into reg0 bit 3 |
| ctrl_o | output | 80 | Stored register bank, reg k at bits 8k+7:8k |

## Verification
The write path is tested in several ways:
- Transfers of different lengths show whether bytes are placed by arrival order and not by the command value.
- Writes that carry non-zero command and count bytes show that both are ignored.
- Full-length and over-length writes separate protected, masked and out-of-range bytes from plain storage.

The read path is tested as follows:
- Reads are taken with different strap and stop-pin levels, to tell live fields apart from stored ones.
- A read that begins after a repeated START, and one that ends with an early NACK, check the framing restart and the bus release.
- A foreign address and a mid-byte abort confirm that neither one disturbs the stored state.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int unsigned NUM_REGS     = 10;
  localparam logic [7:0]  DEV_ADDR     = 8'hD2;
  localparam int unsigned SIG_IDX      = 6;
  localparam logic [7:0]  SIG_VALUE    = 8'h13;
  localparam int unsigned STATUS_IDX   = 0;
  localparam logic [7:0]  STATUS_WMASK = 8'hF9;  // strap bits 2:1 are not stored

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } link_state_e;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h09;
      1:       return 8'h87;
      2:       return 8'hF7;
      3:       return 8'hDF;
      4:       return 8'h3F;
      5:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] line;
  logic [NLINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], raw[g]};
    end
    assign line[g] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= line;
  end

  assign scl_o      = line[1];
  assign sda_o      = line[0];
  assign scl_rise_o = line[1] & ~prev_q[1];
  assign scl_fall_o = ~line[1] & prev_q[1];
  // SDA edges qualified by SCL high on both samples
  assign start_o    = line[1] & prev_q[1] & prev_q[0] & ~line[0];
  assign stop_o     = line[1] & prev_q[1] & ~prev_q[0] & line[0];

endmodule

// File: rtl/smb_link_ctrl.sv
module smb_link_ctrl
  import clkctl_pkg::*;
#(
  parameter logic [7:0]  ADDR  = 8'hD2,
  parameter int unsigned NREGS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_idx_o,
  input  logic [7:0] rd_data_i
);

  localparam logic [7:0] COUNT_BYTE = 8'(NREGS);
  localparam logic [7:0] FIRST_DATA = 8'd3;  // addr, cmd, count precede data

  link_state_e st_q;
  logic [3:0]  bit_cnt_q;
  logic [2:0]  tx_cnt_q;
  logic [7:0]  rx_sh_q, tx_sh_q, byte_no_q, rd_seq_q, wr_idx_q;
  logic        rd_mode_q, acked_q, sda_oe_q, wr_en_q;
  logic [7:0]  tx_byte;
  logic        addr_hit, byte_done;

  assign tx_byte   = (rd_seq_q == 8'd0) ? COUNT_BYTE : rd_data_i;
  assign rd_idx_o  = rd_seq_q - 8'd1;
  assign addr_hit  = (rx_sh_q[7:1] == ADDR[7:1]);
  assign byte_done = (st_q == ST_RX) && scl_fall_i && (bit_cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      tx_cnt_q  <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      byte_no_q <= '0;
      rd_seq_q  <= '0;
      wr_idx_q  <= '0;
      rd_mode_q <= 1'b0;
      acked_q   <= 1'b0;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_RX;
        bit_cnt_q <= '0;
        byte_no_q <= '0;
        rd_seq_q  <= '0;
        acked_q   <= 1'b0;
        sda_oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              rx_sh_q   <= {rx_sh_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_done) begin
              if (byte_no_q == 8'd0 && !addr_hit) begin
                st_q <= ST_IDLE;
              end else begin
                st_q     <= ST_RACK;
                sda_oe_q <= 1'b1;
                if (byte_no_q != 8'hFF) byte_no_q <= byte_no_q + 8'd1;
                if (byte_no_q == 8'd0) rd_mode_q <= rx_sh_q[0];
                if (byte_no_q >= FIRST_DATA) begin
                  wr_en_q  <= 1'b1;
                  wr_idx_q <= byte_no_q - FIRST_DATA;
                end
              end
            end
          end
          ST_RACK: begin
            if (scl_fall_i) begin
              if (rd_mode_q) begin
                st_q     <= ST_TX;
                tx_sh_q  <= tx_byte;
                tx_cnt_q <= '0;
                sda_oe_q <= ~tx_byte[7];
              end else begin
                st_q      <= ST_RX;
                bit_cnt_q <= '0;
                sda_oe_q  <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (tx_cnt_q == 3'd7) begin
                st_q     <= ST_MACK;
                sda_oe_q <= 1'b0;
                acked_q  <= 1'b0;
              end else begin
                tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
                sda_oe_q <= ~tx_sh_q[6];
                tx_cnt_q <= tx_cnt_q + 3'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              if (sda_i) begin
                st_q <= ST_IDLE;
              end else begin
                acked_q <= 1'b1;
                if (rd_seq_q != 8'hFF) rd_seq_q <= rd_seq_q + 8'd1;
              end
            end else if (scl_fall_i && acked_q) begin
              st_q     <= ST_TX;
              tx_sh_q  <= tx_byte;
              tx_cnt_q <= '0;
              sda_oe_q <= ~tx_byte[7];
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = rx_sh_q;

  a_r1_foreign_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !start_i && !stop_i && byte_no_q == 8'd0 &&
     rx_sh_q != ADDR && rx_sh_q != (ADDR | 8'h01))
    |=> (st_q == ST_IDLE && !sda_oe_q));

  a_r10_start_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_RX && bit_cnt_q == 4'd0 && byte_no_q == 8'd0));

  a_r10_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sda_oe_q) |-> !scl_i);

  a_r8_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MACK && scl_rise_i && sda_i && !start_i && !stop_i)
    |=> (st_q == ST_IDLE && !sda_oe_q));

endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
#(
  parameter int unsigned NREGS  = 10,
  parameter int unsigned SIGIDX = 6,
  parameter logic [7:0]  SIGVAL = 8'h13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [7:0]       rd_idx_i,
  output logic [7:0]       rd_data_o,
  input  logic [1:0]       strap_i,
  input  logic             pci_stop_ni,
  output logic [NREGS*8-1:0] ctrl_o
);

  localparam logic [7:0] NREGS_B = 8'(NREGS);
  localparam logic [7:0] SIG_B   = 8'(SIGIDX);
  localparam logic [7:0] STAT_B  = 8'(STATUS_IDX);

  logic [7:0] regs_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    localparam logic [7:0] IDX = 8'(r);
    if (r == SIGIDX) begin : g_const
      assign regs_q[r] = SIGVAL;
    end else begin : g_store
      localparam logic [7:0] WMASK = (r == STATUS_IDX) ? STATUS_WMASK : 8'hFF;
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         q <= reg_default(r);
        else if (wr_en_i && wr_idx_i == IDX) q <= wr_data_i & WMASK;
      end
      assign regs_q[r] = q;

      a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_idx_i == IDX) |=> (q == ($past(wr_data_i) & WMASK)));
    end
    assign ctrl_o[r*8 +: 8] = regs_q[r];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int k = 0; k < NREGS; k++) begin
      if (rd_idx_i == 8'(k)) rd_data_o = regs_q[k];
    end
    if (rd_idx_i == STAT_B) begin
      rd_data_o[3]   = regs_q[STATUS_IDX][3] & pci_stop_ni;
      rd_data_o[2:1] = strap_i;
    end
  end

  a_r7_signature_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == SIG_B) |-> (rd_data_o == SIGVAL));

  a_r9_beyond_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i >= NREGS_B) |-> (rd_data_o == 8'h00));

  a_r6_stop_pin_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == STAT_B && !pci_stop_ni) |-> !rd_data_o[3]);

  a_r7_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == SIG_B) |=> (ctrl_o[SIGIDX*8 +: 8] == SIGVAL));

endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave
  import clkctl_pkg::*;
#(
  parameter int unsigned NREGS       = clkctl_pkg::NUM_REGS,
  parameter logic [7:0]  ADDR        = clkctl_pkg::DEV_ADDR,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [1:0]         strap_i,
  input  logic               pci_stop_ni,
  output logic [NREGS*8-1:0] ctrl_o
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  smb_link_ctrl #(.ADDR(ADDR), .NREGS(NREGS)) i_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx),
    .rd_data_i  (rd_data)
  );

  clkctl_regfile #(.NREGS(NREGS), .SIGIDX(SIG_IDX), .SIGVAL(SIG_VALUE)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_data),
    .strap_i     (strap_i),
    .pci_stop_ni (pci_stop_ni),
    .ctrl_o      (ctrl_o)
  );

endmodule

// File: tb/test_clkctl_smb_slave.sv
`timescale 1ns/1ps
module test_clkctl_smb_slave;

  localparam int NR = 10;
  localparam int Q  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic stop_n = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] ctrl;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] model [NR];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  clkctl_smb_slave i_clkctl_smb_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .pci_stop_ni(stop_n), .ctrl_o(ctrl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    model[0] = 8'h09; model[1] = 8'h87; model[2] = 8'hF7; model[3] = 8'hDF;
    model[4] = 8'h3F; model[5] = 8'h40; model[6] = 8'h13;
    model[7] = 8'h00; model[8] = 8'h00; model[9] = 8'h00;
  endtask

  task automatic model_write(input int idx, input logic [7:0] d);
    if (idx == 0) model[0] = d & 8'hF9;
    else if (idx != 6 && idx < NR) model[idx] = d;
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    int idx = k - 1;
    if (k == 0) return 8'(NR);
    if (idx == 0) return {model[0][7:4], model[0][3] & stop_n, strap, model[0][0]};
    if (idx >= NR) return 8'h00;
    return model[idx];
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_xfer(input logic b, output logic s);
    wq(); sda_m = b;
    wq(); scl_m = 1'b1;
    wq(); s = sda_line;
    wq(); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, s); b[i] = s; end
    bit_xfer(~give_ack, s);
  endtask

  task automatic do_write(input logic [7:0] cmd, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); chk({tag, " R1 addr ack"}, ack, 1);
    send_byte(cmd, ack);   chk("R2 cmd ack", ack, 1);
    send_byte(8'(n), ack); chk("R2 count ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk((i >= NR) ? "R9 beyond ack" : "R3 data ack", ack, 1);
      model_write(i, wbuf[i]);
    end
    bus_stop();
  endtask

  task automatic do_read(input int n);
    logic ack;
    bus_start();
    send_byte(8'hD3, ack); chk("R1 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    chk("R8 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic chk_ctrl(input string tag);
    for (int k = 0; k < NR; k++) chk(tag, ctrl[k*8 +: 8], model[k]);
  endtask

  task automatic t_reset();
    model_reset();
    chk_ctrl("R4 reset ctrl");
    chk("R4 sda idle", sda_oe, 0);
    do_read(NR + 1);
    chk("R8 count byte", rbuf[0], NR);
    for (int k = 1; k <= NR; k++) chk("R4 reset read", rbuf[k], exp_rd(k));
  endtask

  task automatic t_foreign();
    logic ack;
    bus_start();
    send_byte(8'hA4, ack); chk("R1 foreign nack", ack, 0);
    send_byte(8'h00, ack); chk("R1 ignored after nack", ack, 0);
    send_byte(8'h55, ack); chk("R1 ignored after nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD0, ack); chk("R1 near address nack", ack, 0);
    bus_stop();
    chk_ctrl("R1 foreign no effect");
  endtask

  task automatic t_write_basic();
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
    do_write(8'h00, 3, "basic");
    chk("R5 strap bits not stored", ctrl[2:1], 0);
    chk_ctrl("R3 write order");
    do_read(4);
    chk("R3 readback reg1", rbuf[2], 8'h3C);
    chk("R3 readback reg2", rbuf[3], 8'h81);
  endtask

  task automatic t_cmd_ignored();
    wbuf[0] = 8'h10; wbuf[1] = 8'h55;
    do_write(8'hC3, 2, "cmd");
    chk_ctrl("R2 command ignored");
  endtask

  task automatic t_straps();
    strap = 2'b10;
    do_read(2);
    chk("R5 strap 10", rbuf[1], exp_rd(1));
    strap = 2'b01;
    do_read(2);
    chk("R5 strap 01", rbuf[1][2:1], 2'b01);
    strap = 2'b00;
  endtask

  task automatic t_pci_stop();
    wbuf[0] = 8'h08;
    do_write(8'h00, 1, "stop");
    stop_n = 1'b0;
    do_read(2);
    chk("R6 pin low gates bit3", rbuf[1][3], 0);
    chk("R6 stored bit3 kept", ctrl[3], 1);
    stop_n = 1'b1;
    do_read(2);
    chk("R6 pin high passes bit3", rbuf[1][3], 1);
  endtask

  task automatic t_signature();
    for (int i = 0; i < 7; i++) wbuf[i] = 8'hF0 | 8'(i);
    wbuf[6] = 8'hFF;
    do_write(8'h00, 7, "sig");
    chk("R7 signature ctrl", ctrl[6*8 +: 8], 8'h13);
    chk("R7 neighbour written", ctrl[5*8 +: 8], 8'hF5);
    do_read(8);
    chk("R7 signature read", rbuf[7], 8'h13);
  endtask

  task automatic t_beyond();
    for (int i = 0; i < 12; i++) wbuf[i] = 8'h20 + 8'(i);
    do_write(8'h7E, 12, "beyond");
    chk_ctrl("R9 beyond writes no effect");
    do_read(13);
    chk("R9 read reg10", rbuf[11], 0);
    chk("R9 read reg11", rbuf[12], 0);
    chk("R3 read reg9", rbuf[10], 8'h29);
  endtask

  task automatic t_repeated_start();
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    bus_start();
    send_byte(8'hD3, ack); chk("R10 repeated start addr ack", ack, 1);
    recv_byte(1'b1, b);    chk("R10 count after restart", b, NR);
    recv_byte(1'b0, b);    chk("R10 reg0 after restart", b, exp_rd(1));
    bus_stop();
  endtask

  task automatic t_abort_hold();
    logic ack;
    logic s;
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h01, ack);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, s);
    bus_stop();
    chk_ctrl("R11 abort keeps registers");
    repeat (50) @(negedge clk);
    chk_ctrl("R11 held over idle");
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    chk_ctrl("R4 defaults after reset");
  endtask

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_foreign();
    t_write_basic();
    t_cmd_ignored();
    t_straps();
    t_pci_stop();
    t_signature();
    t_beyond();
    t_repeated_start();
    t_abort_hold();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule